// File: doc/BRIEF.md
# Microsequencer Next-Address Unit

This unit decides which control-store word a microprogrammed datapath executes next. Each cycle it takes four inputs: the current microinstruction's 9-bit successor field, three jump-control bits, a pair of condition flags held over from the previous cycle, and the 8-bit instruction byte register. From these it forms the next microprogram counter and registers it. The flags are captured from the ALU at each clock edge, so a branch tests the result of the microinstruction that ran one cycle earlier.

Three kinds of control transfer are supported. A plain jump takes the successor field as is. A two-way branch forces bit 8 of the successor to 1 when the selected flag (negative or zero) is set. The two targets of a branch therefore sit 256 words apart. A multiway dispatch puts the instruction byte into the low eight bits, so that the opcode itself picks one of 256 entries. Bit 8 of the successor field then chooses between the lower bank and the upper bank at 0x100. That bank is reached with a single OR gate rather than an adder. The instruction byte register lives inside this unit. When the byte is loaded in the same cycle as a dispatch, the dispatch uses the incoming byte and not the stale one.

Top module: `useq_next_addr`

## Requirements
- R1: While rst_n is low at a rising edge, upc, mbr, n_flag and z_flag all become 0 on that edge.
- R2: With jam_n, jam_z and jump_mbr all 0, upc after the edge equals next_field.
- R3: n_flag and z_flag take the values of alu_n and alu_z at every rising edge out of reset.
- R4: With jam_z = 1 and jump_mbr = 0, upc after the edge is next_field with bit 8 set if z_flag was 1 before the edge, and next_field unchanged otherwise. The live alu_z input has no effect on this cycle's choice.
- R5: With jam_n = 1 and jump_mbr = 0, the same rule applies using n_flag. The live alu_n input has no effect.
- R6: With both jam_n and jam_z set, bit 8 is forced when either selected flag is 1.
- R7: With jump_mbr = 1 and next_field bit 8 = 0 (no branch taken), upc after the edge equals the byte register value zero-extended. Bits 7..0 of next_field are ignored.
- R8: With jump_mbr = 1 and next_field bit 8 = 1, upc after the edge equals 0x100 OR the byte value.
- R9: When mbr_load and jump_mbr are both 1 in a cycle, the dispatch uses mbr_in of that cycle, not the previously held byte.
- R10: mbr takes mbr_in at an edge where mbr_load = 1 and holds its value when mbr_load = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| next_field | input | 9 | Successor address field of the current microinstruction |
| jam_n | input | 1 | Branch on the latched negative flag |
| jam_z | input | 1 | Branch on the latched zero flag |
| jump_mbr | input | 1 | Dispatch on the instruction byte |
| alu_n | input | 1 | Negative result from the ALU this cycle |
| alu_z | input | 1 | Zero result from the ALU this cycle |
| mbr_load | input | 1 | Load mbr_in into the byte register at this edge |
| mbr_in | input | 8 | Instruction byte arriving from program memory |
| upc | output | 9 | Registered microprogram counter |
| mbr | output | 8 | Held instruction byte |
| n_flag | output | 1 | Latched negative flag |
| z_flag | output | 1 | Latched zero flag |

## Verification
A byte load and a dispatch can fall in the same cycle. A flag capture and a branch on that same flag also coincide every cycle. The sweep drives mbr_in with a byte that differs from the held one whenever mbr_load and jump_mbr are raised together. It also sets alu_n and alu_z to the opposite of the latched flags during every branch cycle. A correct result then requires the fresh byte in the first case and the old flag in the second. Every cycle is scored against a bench model built from the requirements, covering all control, flag, bank and load combinations.

// File: rtl/useq_pkg.sv
// Package: shared types and widths for the next-address unit.
// Assumes the control store holds exactly two banks of 2**MBR_W words.
package useq_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned UADDR_W = BYTE_W + 1;

    // Jump-control bits carried by each microinstruction.
    typedef struct packed {
        logic jam_n;
        logic jam_z;
        logic jump_mbr;
    } jump_ctl_t;

    // Dispatch merge variants: replace low bits, or OR them with the field.
    typedef enum logic {
        MERGE_REPLACE = 1'b0,
        MERGE_OR      = 1'b1
    } merge_mode_e;
endpackage

// File: rtl/useq_flag_reg.sv
// Flag register: holds the ALU negative and zero results for one cycle so
// the next microinstruction can branch on them.
// Assumes the ALU outputs are valid before every rising edge.
module useq_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic alu_n,
    input  logic alu_z,
    output logic n_q,
    output logic z_q
);
    // Capture both flags at every edge; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            n_q <= alu_n;
            z_q <= alu_z;
        end
    end
endmodule

// File: rtl/useq_mbr_latch.sv
// Instruction byte register with a bypass: eff shows the byte that is being
// loaded this cycle, and otherwise the held byte.
// Assumes din is stable before the edge whenever load is high.
module useq_mbr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] eff
);
    // Load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

    // Forward the incoming byte so a dispatch in the same cycle sees it.
    always_comb eff = load ? din : q;
endmodule

// File: rtl/useq_addr_mux.sv
// Next-address former: forces bit 8 for a taken branch and puts the
// dispatch byte into the low bits. Purely combinational.
// Assumes AW == MW + 1, so bit AW-1 selects the upper bank.
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int unsigned MW         = 8,
    parameter merge_mode_e MERGE_MODE = MERGE_REPLACE,
    localparam int unsigned AW        = MW + 1
) (
    input  logic [AW-1:0] field,
    input  jump_ctl_t     ctl,
    input  logic          n_q,
    input  logic          z_q,
    input  logic [MW-1:0] byte_eff,
    output logic [AW-1:0] next_addr
);
    logic          take;
    logic          bank;
    logic [MW-1:0] low;

    // Branch condition from the latched flags.
    always_comb take = (ctl.jam_n & n_q) | (ctl.jam_z & z_q);

    // Bank bit: the field's own bit 8, or forced by a taken branch.
    always_comb bank = field[AW-1] | take;

    generate
        if (MERGE_MODE == MERGE_OR) begin : g_or
            // Dispatch ORs the byte into the field's low bits.
            always_comb low = ctl.jump_mbr ? (field[MW-1:0] | byte_eff)
                                           : field[MW-1:0];
        end else begin : g_replace
            // Dispatch replaces the field's low bits with the byte.
            always_comb low = ctl.jump_mbr ? byte_eff : field[MW-1:0];
        end
    endgenerate

    // Assemble the successor address.
    always_comb next_addr = {bank, low};
endmodule

// File: rtl/useq_next_addr.sv
// Top of the microsequencer next-address unit: flag register, instruction
// byte register with bypass, address former, and microprogram counter.
// Assumes a synchronous active-low reset that starts execution at word 0.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int unsigned MBR_W      = BYTE_W,
    parameter merge_mode_e MERGE_MODE = MERGE_REPLACE,
    localparam int unsigned AW        = MBR_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] next_field,
    input  logic          jam_n,
    input  logic          jam_z,
    input  logic          jump_mbr,
    input  logic          alu_n,
    input  logic          alu_z,
    input  logic          mbr_load,
    input  logic [MBR_W-1:0] mbr_in,
    output logic [AW-1:0] upc,
    output logic [MBR_W-1:0] mbr,
    output logic          n_flag,
    output logic          z_flag
);
    jump_ctl_t        ctl;
    logic [MBR_W-1:0] byte_eff;
    logic [AW-1:0]    next_addr;

    // Gather the jump-control bits.
    always_comb ctl = '{jam_n: jam_n, jam_z: jam_z, jump_mbr: jump_mbr};

    useq_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .alu_n (alu_n),
        .alu_z (alu_z),
        .n_q   (n_flag),
        .z_q   (z_flag)
    );

    useq_mbr_latch #(.W(MBR_W)) u_mbr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mbr_load),
        .din   (mbr_in),
        .q     (mbr),
        .eff   (byte_eff)
    );

    useq_addr_mux #(.MW(MBR_W), .MERGE_MODE(MERGE_MODE)) u_mux (
        .field     (next_field),
        .ctl       (ctl),
        .n_q       (n_flag),
        .z_q       (z_flag),
        .byte_eff  (byte_eff),
        .next_addr (next_addr)
    );

    // Microprogram counter: restart at 0, else advance to the formed address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upc <= '0;
        else
            upc <= next_addr;
    end
endmodule

// File: rtl/useq_next_addr_chk.sv
// Checker for the next-address unit, bound to every instance of the top.
// Assumes the default replace merge mode for the dispatch properties.
module useq_next_addr_chk #(
    parameter int unsigned MBR_W = 8,
    localparam int unsigned AW   = MBR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    next_field,
    input logic             jam_n,
    input logic             jam_z,
    input logic             jump_mbr,
    input logic             alu_n,
    input logic             alu_z,
    input logic             mbr_load,
    input logic [MBR_W-1:0] mbr_in,
    input logic [AW-1:0]    upc,
    input logic [MBR_W-1:0] mbr,
    input logic             n_flag,
    input logic             z_flag
);
    // R1: reset clears the counter.
    a_r1_reset_upc: assert property (@(posedge clk)
        !rst_n |=> (upc == '0));

    // R2: plain jump follows the field.
    a_r2_plain_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam_n && !jam_z && !jump_mbr) |=> (upc == $past(next_field)));

    // R3: flags follow the ALU one edge later.
    a_r3_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (n_flag == $past(alu_n) && z_flag == $past(alu_z)));

    // R4: a taken zero branch lands in the upper bank.
    a_r4_z_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_z && z_flag && !jump_mbr) |=> upc[AW-1]);

    // R5: a taken negative branch lands in the upper bank.
    a_r5_n_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_n && n_flag && !jump_mbr) |=> upc[AW-1]);

    // R9: a dispatch in the load cycle uses the incoming byte.
    a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_mbr && mbr_load) |=> (upc[MBR_W-1:0] == $past(mbr_in)));

    // R10: the byte register holds without a load.
    a_r10_mbr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mbr_load |=> $stable(mbr));
endmodule

bind useq_next_addr useq_next_addr_chk #(.MBR_W(MBR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_field (next_field),
    .jam_n      (jam_n),
    .jam_z      (jam_z),
    .jump_mbr   (jump_mbr),
    .alu_n      (alu_n),
    .alu_z      (alu_z),
    .mbr_load   (mbr_load),
    .mbr_in     (mbr_in),
    .upc        (upc),
    .mbr        (mbr),
    .n_flag     (n_flag),
    .z_flag     (z_flag)
);

// File: tb/useq_next_addr_test.sv
`timescale 1ns/1ps
// Sweeps every combination of jump control, latched flags, bank bit and
// byte load, and scores each cycle against a model built from the brief.
module useq_next_addr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] next_field = '0;
    logic       jam_n = 1'b0, jam_z = 1'b0, jump_mbr = 1'b0;
    logic       alu_n = 1'b0, alu_z = 1'b0;
    logic       mbr_load = 1'b0;
    logic [7:0] mbr_in = '0;
    logic [8:0] upc;
    logic [7:0] mbr;
    logic       n_flag, z_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    logic [8:0] m_upc = '0;
    logic [7:0] m_mbr = '0;
    logic       m_n = 1'b0, m_z = 1'b0;

    always #10 clk = ~clk;

    useq_next_addr uut (
        .clk(clk), .rst_n(rst_n), .next_field(next_field),
        .jam_n(jam_n), .jam_z(jam_z), .jump_mbr(jump_mbr),
        .alu_n(alu_n), .alu_z(alu_z), .mbr_load(mbr_load), .mbr_in(mbr_in),
        .upc(upc), .mbr(mbr), .n_flag(n_flag), .z_flag(z_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clocked cycle: inputs were set after a falling edge; predict, clock, compare.
    task automatic cycle();
        logic       cond;
        logic [7:0] eff;
        logic [8:0] exp_upc;
        string      tag;
        cond = (jam_n & m_n) | (jam_z & m_z);
        eff  = mbr_load ? mbr_in : m_mbr;
        exp_upc = {next_field[8] | cond, jump_mbr ? eff : next_field[7:0]};
        if (jump_mbr) tag = mbr_load ? "R9" : (next_field[8] ? "R8" : "R7");
        else if (jam_n && jam_z) tag = "R6";
        else if (jam_z) tag = "R4";
        else if (jam_n) tag = "R5";
        else tag = "R2";
        @(posedge clk);
        if (rst_n) begin
            m_upc = exp_upc;
            m_mbr = eff;
            m_n = alu_n;
            m_z = alu_z;
        end
        @(negedge clk);
        if (!rst_n) begin
            check("R1 upc", upc, 0);
            check("R1 mbr", mbr, 0);
            check("R1 flags", {n_flag, z_flag}, 0);
            m_upc = '0; m_mbr = '0; m_n = 1'b0; m_z = 1'b0;
        end else begin
            check(tag, upc, m_upc);
            check("R10 mbr", mbr, m_mbr);
            check("R3 flags", {n_flag, z_flag}, {m_n, m_z});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20ns * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle();                           // R1: reset state
        rst_n = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < 8; c++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int ld = 0; ld < 2; ld++) begin
                        for (int b8 = 0; b8 < 2; b8++) begin
                            // Set-up cycle: plain jump that loads the flags and a byte.
                            {jam_n, jam_z, jump_mbr} = 3'b000;
                            next_field = 9'((c * 37 + f * 11 + rep * 101) & 9'h1ff);
                            alu_n = f[1]; alu_z = f[0];
                            mbr_load = 1'b1;
                            mbr_in = 8'(c * 29 + f * 7 + b8 * 3 + rep * 90);
                            cycle();
                            // Test cycle: live ALU inputs oppose the latched flags (R4/R5).
                            {jam_n, jam_z, jump_mbr} = 3'(c);
                            next_field = {1'(b8), 8'(8'h5a ^ 8'(c * 19 + f))};
                            alu_n = ~f[1]; alu_z = ~f[0];
                            mbr_load = 1'(ld);
                            mbr_in = ~mbr_in;      // differs from the held byte (R9)
                            cycle();
                        end
                    end
                end
            end
        end
        // Mid-run reset clears everything (R1).
        mbr_load = 1'b1; mbr_in = 8'hff; alu_n = 1'b1; alu_z = 1'b1;
        rst_n = 1'b0;
        cycle();
        rst_n = 1'b1;
        mbr_load = 1'b0; {jam_n, jam_z, jump_mbr} = 3'b001; next_field = 9'h1c3;
        cycle();                           // R8: dispatch on cleared byte
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule